// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block finds the PLL divider setting whose output frequency comes closest to a requested rate without going above it. A caller presents a reference (parent) rate and a target rate and pulses a start input. The engine then steps through every legal feedback/reference divider pair. For each pair whose VCO frequency falls inside the allowed window, it steps through every combination of the two post-dividers. It keeps the best candidate found and returns that candidate's rate together with a packed divider control word. It raises an error flag when no candidate qualifies.

All division is done by one shared, bit-serial restoring divider. Each candidate evaluation launches the divider and waits for its quotient before comparing. Every range, window and width is a parameter. The defaults give a 64-bit rate datapath, feedback 8..1066, reference 1..63, post-dividers 0..7, a VCO window of 1.6 to 3.2 GHz and an output clamp of 25 kHz to 3.2 GHz.

Top module: `pll_div_search`

## Requirements
- R1: A candidate's rate is floor(parent × fb / (ref × (pd1+1) × (pd2+1))), using truncating integer division.
- R2: A fb/ref pair is used only if floor(parent × fb / ref) lies inside [VCO_MIN, VCO_MAX], inclusive. Any other pair is skipped with no post-divider candidates.
- R3: fb runs from FB_MIN to FB_MAX as the outer loop, with ref from RF_MIN to RF_MAX inside it. For each accepted pair, pd2 runs 0..PD_MAX as the outer loop and pd1 runs 0..PD_MAX inside it.
- R4: A candidate whose rate is above the (clamped) target is never chosen. The reported rate never exceeds the clamped target.
- R5: The best rate starts at 0. A candidate replaces it only when it is strictly closer to the target, so on a tie the candidate earliest in R3 order is kept.
- R6: A candidate equal to the target ends the whole search at once, so the result arrives sooner than with a full search.
- R7: Before searching, the target is clamped into [OUT_MIN, OUT_MAX].
- R8: If no candidate is found (best rate stays 0), err_o is 1 and rate_o and ctrl_o are 0.
- R9: ctrl_o packs fb in bits 11:0, ref in bits 17:12, pd1 in bits 20:18 and pd2 in bits 23:21.
- R10: done_o is high for exactly one cycle per accepted start, with rate_o, ctrl_o and err_o valid in that cycle. A start while a search is running is ignored.
- R11: After reset, done_o, err_o, rate_o and ctrl_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a search when the engine is idle |
| parent_rate_i | input | RATE_W | Reference clock rate |
| target_rate_i | input | RATE_W | Requested output rate |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No legal candidate was found |
| rate_o | output | RATE_W | Achieved output rate |
| ctrl_o | output | FB_W+RF_W+2*PD_W | Packed divider control word |

## Verification
The engine is run with a reduced parameter set so that full searches stay short. Stimulus comes in four groups:
- An exactly reachable target on the first accepted pair checks the field packing against a hand-worked word, and its latency is compared with a full search to show the early stop.
- Unreachable targets force a full search, which exposes the loop order and the tie rule.
- Targets above and below the clamp limits, plus a parent rate too low for any VCO-valid pair, separate the clamp path from the error path.
- A second start issued mid-search checks that the first request alone is answered, with a single done pulse.

// File: rtl/pllsrch_pkg.sv
// Package: shared state encoding for the PLL divider search engine.
// Assumes: nothing beyond IEEE 1800-2017.
package pllsrch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VCO_GO,
        ST_VCO_WAIT,
        ST_PD_GO,
        ST_PD_WAIT,
        ST_FINISH
    } srch_st_e;

endpackage

// File: rtl/pllsrch_div.sv
// Module: bit-serial restoring unsigned divider.
// Produces floor(num/den) NUM_W cycles after go_i; done_o pulses for one cycle
// with quo_o valid. Assumes den_i is non-zero and go_i only arrives while idle.
module pllsrch_div #(
    parameter int NUM_W = 76,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   rem_q;
    logic [DEN_W:0]   den_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W:0]   shifted;
    logic             fit;
    logic [DEN_W:0]   rem_nxt;

    // Trial subtraction for one quotient bit.
    always_comb begin
        shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        fit     = (shifted >= den_q);
        rem_nxt = fit ? (shifted - den_q) : shifted;
    end

    // Iteration register: load operands, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(NUM_W);
                rem_q  <= '0;
                den_q  <= {1'b0, den_i};
                quo_q  <= num_i;
            end else if (busy_q) begin
                rem_q <= rem_nxt;
                quo_q <= {quo_q[NUM_W-2:0], fit};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;

    // A zero divisor would make every candidate rate meaningless (R1).
    assert_den_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (den_i != '0));

    // A launch is never issued while a division is in flight (R1).
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_q);

endmodule

// File: rtl/pllsrch_iter.sv
// Module: two-level nested range counter.
// The inner index runs I_MIN..I_MAX for each outer index O_MIN..O_MAX.
// clr_i restarts at (O_MIN, I_MIN); step_i advances one position.
// last_o flags the final position. Assumes the ranges fit the widths.
module pllsrch_iter #(
    parameter int W_OUT = 12,
    parameter int W_IN  = 6,
    parameter int O_MIN = 8,
    parameter int O_MAX = 1066,
    parameter int I_MIN = 1,
    parameter int I_MAX = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [W_OUT-1:0] outer_o,
    output logic [W_IN-1:0]  inner_o,
    output logic             last_o
);
    localparam logic [W_OUT-1:0] OMIN = W_OUT'(O_MIN);
    localparam logic [W_OUT-1:0] OMAX = W_OUT'(O_MAX);
    localparam logic [W_IN-1:0]  IMIN = W_IN'(I_MIN);
    localparam logic [W_IN-1:0]  IMAX = W_IN'(I_MAX);

    // Position register: restart on clear, inner-first increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            outer_o <= OMIN;
            inner_o <= IMIN;
        end else if (step_i) begin
            if (inner_o == IMAX) begin
                inner_o <= IMIN;
                outer_o <= (outer_o == OMAX) ? OMIN : outer_o + W_OUT'(1);
            end else begin
                inner_o <= inner_o + W_IN'(1);
            end
        end
    end

    assign last_o = (outer_o == OMAX) && (inner_o == IMAX);

    // Inner index advances by exactly one inside its range (R3).
    assert_inner_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && inner_o != IMAX) |=>
            (inner_o == W_IN'($past(inner_o) + W_IN'(1))) && $stable(outer_o));

    // Inner index wraps to its minimum when the outer index moves (R3).
    assert_inner_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && inner_o == IMAX) |=> (inner_o == IMIN));

endmodule

// File: rtl/pll_div_search.sv
// Module: PLL divider setting search engine (top).
// Scans fb/ref pairs (fb outer), keeps pairs whose VCO rate is inside the
// window, and for each scans pd2/pd1 (pd2 outer). It keeps the highest rate
// not above the clamped target and stops on an exact hit. Assumes the range
// parameters fit the field widths and that RF_MIN >= 1.
module pll_div_search
    import pllsrch_pkg::*;
#(
    parameter int          RATE_W  = 64,
    parameter int          FB_W    = 12,
    parameter int          RF_W    = 6,
    parameter int          PD_W    = 3,
    parameter int          FB_MIN  = 8,
    parameter int          FB_MAX  = 1066,
    parameter int          RF_MIN  = 1,
    parameter int          RF_MAX  = 63,
    parameter int          PD_MAX  = 7,
    parameter logic [63:0] VCO_MIN = 64'd1600000000,
    parameter logic [63:0] VCO_MAX = 64'd3200000000,
    parameter logic [63:0] OUT_MIN = 64'd25000,
    parameter logic [63:0] OUT_MAX = 64'd3200000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [RATE_W-1:0]             parent_rate_i,
    input  logic [RATE_W-1:0]             target_rate_i,
    output logic                          done_o,
    output logic                          err_o,
    output logic [RATE_W-1:0]             rate_o,
    output logic [FB_W+RF_W+2*PD_W-1:0]   ctrl_o
);
    localparam int NUM_W = RATE_W + FB_W;
    localparam int DEN_W = RF_W + 2 * PD_W;
    localparam int CW_W  = FB_W + RF_W + 2 * PD_W;
    localparam logic [NUM_W-1:0]  VMIN_N = NUM_W'(VCO_MIN);
    localparam logic [NUM_W-1:0]  VMAX_N = NUM_W'(VCO_MAX);
    localparam logic [RATE_W-1:0] OMIN_R = RATE_W'(OUT_MIN);
    localparam logic [RATE_W-1:0] OMAX_R = RATE_W'(OUT_MAX);

    srch_st_e            st, st_n;
    logic [RATE_W-1:0]   par_q, tgt_q, best_q, tgt_clamped;
    logic [CW_W-1:0]     best_ctrl_q;
    logic [FB_W-1:0]     fb_c;
    logic [RF_W-1:0]     rf_c;
    logic [PD_W-1:0]     p1_c, p2_c;
    logic                pair_last, pd_last;
    logic                pair_clr, pair_step, pd_clr, pd_step;
    logic                div_go, div_done;
    logic [NUM_W-1:0]    div_num, quo;
    logic [DEN_W-1:0]    div_den, pd_den;
    logic [NUM_W-1:0]    tgt_n, best_n;
    logic                vco_ok, fits, better, exact;

    // fb/ref pair sequencer: fb outer, ref inner.
    pllsrch_iter #(
        .W_OUT(FB_W), .W_IN(RF_W),
        .O_MIN(FB_MIN), .O_MAX(FB_MAX), .I_MIN(RF_MIN), .I_MAX(RF_MAX)
    ) pair_it (
        .clk(clk), .rst_n(rst_n), .clr_i(pair_clr), .step_i(pair_step),
        .outer_o(fb_c), .inner_o(rf_c), .last_o(pair_last)
    );

    // Post-divider sequencer: pd2 outer, pd1 inner.
    pllsrch_iter #(
        .W_OUT(PD_W), .W_IN(PD_W),
        .O_MIN(0), .O_MAX(PD_MAX), .I_MIN(0), .I_MAX(PD_MAX)
    ) pd_it (
        .clk(clk), .rst_n(rst_n), .clr_i(pd_clr), .step_i(pd_step),
        .outer_o(p2_c), .inner_o(p1_c), .last_o(pd_last)
    );

    // Shared divider for both the VCO check and the candidate rate.
    pllsrch_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) div_u (
        .clk(clk), .rst_n(rst_n), .go_i(div_go),
        .num_i(div_num), .den_i(div_den), .done_o(div_done), .quo_o(quo)
    );

    // Operand build, target clamp and candidate comparisons.
    always_comb begin
        div_num = NUM_W'(par_q) * NUM_W'(fb_c);
        pd_den  = DEN_W'(rf_c)
                * DEN_W'({1'b0, p1_c} + (PD_W+1)'(1))
                * DEN_W'({1'b0, p2_c} + (PD_W+1)'(1));
        div_den = (st == ST_VCO_GO) ? DEN_W'(rf_c) : pd_den;
        div_go  = (st == ST_VCO_GO) || (st == ST_PD_GO);
        tgt_clamped = (target_rate_i < OMIN_R) ? OMIN_R :
                      (target_rate_i > OMAX_R) ? OMAX_R : target_rate_i;
        tgt_n  = NUM_W'(tgt_q);
        best_n = NUM_W'(best_q);
        vco_ok = (quo >= VMIN_N) && (quo <= VMAX_N);
        fits   = (quo <= tgt_n);
        better = fits && (quo > best_n);
        exact  = fits && (quo == tgt_n);
    end

    // Next-state and sequencer control.
    always_comb begin
        st_n      = st;
        pair_clr  = 1'b0;
        pair_step = 1'b0;
        pd_clr    = 1'b0;
        pd_step   = 1'b0;
        case (st)
            ST_IDLE: if (start_i) begin
                pair_clr = 1'b1;
                st_n     = ST_VCO_GO;
            end
            ST_VCO_GO: st_n = ST_VCO_WAIT;
            ST_VCO_WAIT: if (div_done) begin
                if (vco_ok) begin
                    pd_clr = 1'b1;
                    st_n   = ST_PD_GO;
                end else if (pair_last) begin
                    st_n = ST_FINISH;
                end else begin
                    pair_step = 1'b1;
                    st_n      = ST_VCO_GO;
                end
            end
            ST_PD_GO: st_n = ST_PD_WAIT;
            ST_PD_WAIT: if (div_done) begin
                if (exact) begin
                    st_n = ST_FINISH;
                end else if (!pd_last) begin
                    pd_step = 1'b1;
                    st_n    = ST_PD_GO;
                end else if (pair_last) begin
                    st_n = ST_FINISH;
                end else begin
                    pair_step = 1'b1;
                    st_n      = ST_VCO_GO;
                end
            end
            ST_FINISH: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // State, request capture, best tracking and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            par_q       <= '0;
            tgt_q       <= '0;
            best_q      <= '0;
            best_ctrl_q <= '0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
            rate_o      <= '0;
            ctrl_o      <= '0;
        end else begin
            st     <= st_n;
            done_o <= 1'b0;
            if (st == ST_IDLE && start_i) begin
                par_q       <= parent_rate_i;
                tgt_q       <= tgt_clamped;
                best_q      <= '0;
                best_ctrl_q <= '0;
            end
            if (st == ST_PD_WAIT && div_done && better) begin
                best_q      <= quo[RATE_W-1:0];
                best_ctrl_q <= {p2_c, p1_c, rf_c, fb_c};
            end
            if (st == ST_FINISH) begin
                done_o <= 1'b1;
                err_o  <= (best_q == '0);
                rate_o <= best_q;
                ctrl_o <= (best_q == '0) ? '0 : best_ctrl_q;
            end
        end
    end

    // Completion is a single-cycle pulse (R10).
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Request operands are frozen while a search runs (R10).
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(par_q) && $stable(tgt_q)));

    // Error results carry zero rate and zero control word (R8).
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (rate_o == '0 && ctrl_o == '0));

    // The reported rate never exceeds the clamped target (R4).
    assert_no_exceed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rate_o <= tgt_q));

    // The target under search lies inside the clamp window (R7).
    assert_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (tgt_q >= OMIN_R && tgt_q <= OMAX_R));

    // The best rate never drops while candidates are compared (R5).
    assert_best_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PD_WAIT) |=> (best_q >= $past(best_q)));

endmodule

// File: tb/pll_div_search_tb_top.sv
// Bench: scoreboard for pll_div_search using a reduced parameter set.
// The driver pushes reference-model results into a queue; the monitor pops
// one entry on every done pulse and compares it with the outputs.
module pll_div_search_tb_top;
    localparam int          RW  = 16;
    localparam int          FBL = 8,  FBH = 15;
    localparam int          RFL = 1,  RFH = 3;
    localparam int          PDH = 3;
    localparam longint      VLO = 1600, VHI = 3200;
    localparam longint      OLO = 25,   OHI = 3200;

    typedef struct {
        longint      rate;
        logic [23:0] ctrl;
        logic        err;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] par = '0;
    logic [RW-1:0] tgt = '0;
    logic          done_o, err_o;
    logic [RW-1:0] rate_o;
    logic [23:0]   ctrl_o;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    pll_div_search #(
        .RATE_W(RW), .FB_MIN(FBL), .FB_MAX(FBH), .RF_MIN(RFL), .RF_MAX(RFH),
        .PD_MAX(PDH), .VCO_MIN(64'd1600), .VCO_MAX(64'd3200),
        .OUT_MIN(64'd25), .OUT_MAX(64'd3200)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .parent_rate_i(par), .target_rate_i(tgt),
        .done_o(done_o), .err_o(err_o), .rate_o(rate_o), .ctrl_o(ctrl_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference search written from the requirements (R1..R9).
    function automatic exp_t model(input longint p, input longint t_in, input string tag);
        exp_t   e;
        longint t, best, q, vco, d;
        bit     hit;
        t    = (t_in < OLO) ? OLO : (t_in > OHI) ? OHI : t_in;
        best = 0;
        hit  = 1'b0;
        e.ctrl = '0;
        for (int fb = FBL; fb <= FBH && !hit; fb++) begin
            for (int rf = RFL; rf <= RFH && !hit; rf++) begin
                vco = (p * fb) / rf;
                if (vco >= VLO && vco <= VHI) begin
                    for (int p2 = 0; p2 <= PDH && !hit; p2++) begin
                        for (int p1 = 0; p1 <= PDH && !hit; p1++) begin
                            d = longint'(rf * (p1 + 1) * (p2 + 1));
                            q = (p * fb) / d;
                            if (q <= t && q > best) begin
                                best   = q;
                                e.ctrl = {3'(p2), 3'(p1), 6'(rf), 12'(fb)};
                                if (q == t) hit = 1'b1;
                            end
                        end
                    end
                end
            end
        end
        e.rate = best;
        e.err  = (best == 0);
        if (e.err) e.ctrl = '0;
        e.tag = tag;
        return e;
    endfunction

    // Monitor: compare every completion with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(longint'(rate_o) == e.rate, e.tag, "rate", longint'(rate_o), e.rate);
                check(ctrl_o == e.ctrl, e.tag, "ctrl", longint'(ctrl_o), longint'(e.ctrl));
                check(err_o == e.err, e.tag, "err", longint'(err_o), longint'(e.err));
            end
        end
    end

    // Driver: push expectation, pulse start, wait for completion.
    task automatic run_case(input longint p, input longint t, input string tag,
                            output int lat);
        exp_q.push_back(model(p, t, tag));
        @(negedge clk);
        par   = RW'(p);
        tgt   = RW'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done_o) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        check(!done_o, "R10", "done width", longint'(done_o), 0);
    endtask

    initial begin
        int lat_exact, lat_full, lat_x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o, "R11", "reset done", longint'(done_o), 0);
        check(!err_o, "R11", "reset err", longint'(err_o), 0);
        check(rate_o == '0 && ctrl_o == '0, "R11", "reset data",
              longint'(rate_o), 0);

        // R9/R6: exact on first pair, fb=8 ref=1 pd1=1 pd2=0 -> 0x041008.
        run_case(250, 1000, "R9", lat_exact);
        check(ctrl_o == 24'h041008, "R9", "hand-packed word", longint'(ctrl_o), 24'h041008);
        check(rate_o == 16'd1000, "R1", "exact rate", longint'(rate_o), 1000);
        // R1/R5: unreachable target forces a full search.
        run_case(250, 777, "R5", lat_full);
        check(lat_exact < lat_full, "R6", "early stop latency", lat_exact, lat_full);
        // R7: clamp high then clamp low (low one has no candidate: R8).
        run_case(250, 5000, "R7", lat_x);
        run_case(250, 3, "R7", lat_x);
        // R8: parent too slow for any VCO-valid pair.
        run_case(10, 500, "R8", lat_x);
        // R2/R3/R4: other parents and targets.
        run_case(333, 700, "R2", lat_x);
        run_case(199, 1234, "R3", lat_x);
        run_case(250, 2000, "R4", lat_x);
        run_case(301, 411, "R1", lat_x);

        // R10: a second start mid-search is ignored.
        exp_q.push_back(model(250, 777, "R10"));
        @(negedge clk);
        par = 16'd250; tgt = 16'd777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        par = 16'd300; tgt = 16'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (6000) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending items", exp_q.size(), 0);
        check(!done_o, "R10", "no second done", longint'(done_o), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R10", "watchdog expired", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule